// File: doc/BRIEF.md
# Interlace Address and Chaining Unit

This block keeps the address, word-count and chain state that one channel uses for direct memory transfers. A control path sets up a transfer in steps. An alert clears the address and count. A 24-bit interlace word then loads their low fields and turns interlace on. An optional mode word adds the high bits. A chain word can also be written to arm a single jump to a new page.

While interlace is on, the transfer logic pulses a step input once for each word it moves. On each step the address advances by one and the count goes down by one. If a chain jump is armed and the advanced address begins a page, the address moves to the start of the chained page instead. The jump can raise a one-cycle interrupt. When the count reaches zero, interlace turns off. A readback request returns the current address on the next cycle.

The controller has three named states. `ST_IDLE` means interlace is off; reset enters it. `ST_ALERTED` means the registers have been cleared and the unit waits for an interlace word. `ST_ACTIVE` means interlace is on.

The transitions are:
- alert: any state goes to `ST_ALERTED`.
- load: any state goes to `ST_ACTIVE`.
- drain: `ST_ACTIVE` goes to `ST_IDLE` when a step makes the count zero.

Top module: `ilc_chain_unit`

## Requirements
- R1: A synchronous reset clears the address, the count, the chain register and the pending flag. It drops the interrupt and readback-valid outputs and enters `ST_IDLE`. In that state `wc_zero_o` is 1 and `ilce_o` is 0.
- R2: An interlace load replaces the low 14 bits of the address with `ctl_word_i[13:0]` and the low 10 bits of the count with `ctl_word_i[23:14]`. The high bits are kept, and the unit enters `ST_ACTIVE` (`ilce_o` = 1).
- R3: A mode load writes `ctl_word_i[1:0]` into address bits 15:14 and `ctl_word_i[6:2]` into count bits 14:10. The low fields are kept.
- R4: A chain write stores `dcr_i` and sets `chain_pend_o`. Bit 5 of `dcr_i` arms the interrupt and bits 4:0 give the page. The pending flag stays set through steps that do not reach a page start.
- R5: In `ST_ACTIVE`, each step adds one to the 16-bit address and takes one from the 15-bit count.
- R6: If a step finds the flag pending and the advanced address has its low 11 bits at zero, the address becomes the page number times 2048 and the pending flag clears. In that case `chain_irq_o` pulses for one cycle, but only if chain bit 5 was set.
- R7: A readback request makes `rd_vld_o` high on the next cycle, with `rd_mar_o` equal to the address held when the request was made.
- R8: A step that brings the count to zero returns the unit to `ST_IDLE` (`ilce_o` = 0, `wc_zero_o` = 1).
- R9: A step while not in `ST_ACTIVE` leaves the address and the count unchanged.
- R10: A step in `ST_ACTIVE` with a count of zero wraps the count to 7FFF hex and stays in `ST_ACTIVE`.
- R11: An alert clears the address and the count and enters `ST_ALERTED` (`ilce_o` = 0). It leaves the chain state unchanged.
- R12: When commands come in the same cycle, the order of priority is alert, then interlace load, then mode load, then step. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alert_i | input | 1 | Clear address and count, await interlace word |
| ilc_load_i | input | 1 | Load low fields from ctl_word_i |
| mode_load_i | input | 1 | Load high fields from ctl_word_i |
| ctl_word_i | input | 24 | Interlace or mode control word |
| dcr_load_i | input | 1 | Write chain register |
| dcr_i | input | 6 | Chain word: bit 5 interrupt arm, bits 4:0 page |
| step_i | input | 1 | One word transferred |
| rd_req_i | input | 1 | Address readback request |
| mar_o | output | 16 | Current memory address |
| wcr_o | output | 15 | Current word count |
| wc_zero_o | output | 1 | Word count is zero |
| ilce_o | output | 1 | Interlace enabled (`ST_ACTIVE`) |
| chain_pend_o | output | 1 | Chain jump armed |
| chain_irq_o | output | 1 | One-cycle chain interrupt |
| rd_vld_o | output | 1 | Readback data valid |
| rd_mar_o | output | 16 | Readback address |

## Verification
The bench uses the default parameters: a 16-bit address, 11 offset bits, a 15-bit count and 10/14-bit low fields. With these, interlace words that place the address one or two words below a page start reach a chain jump within one or two steps. A count loaded as zero reaches the 15-bit wrap in a single step. Readback values pass through a scoreboard queue, and the chain jump is exercised both with and without the interrupt arm bit.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ALERTED = 2'd1,
        ST_ACTIVE  = 2'd2
    } ilc_state_e;
endpackage

// File: rtl/ilc_addr_step.sv
// Next-address computation: plain increment or a one-shot jump to a chained page.
module ilc_addr_step #(
    parameter int MAR_W = 16,
    parameter int OFF_W = 11,
    localparam int PAGE_W = MAR_W - OFF_W,
    localparam int DCR_W  = PAGE_W + 1
) (
    input  logic [MAR_W-1:0] mar_i,
    input  logic             pend_i,
    input  logic [DCR_W-1:0] dcr_i,
    output logic [MAR_W-1:0] mar_next_o,
    output logic             take_o,
    output logic             irq_o
);
    logic [MAR_W-1:0] inc;

    always_comb begin
        inc        = mar_i + MAR_W'(1);
        take_o     = pend_i && (inc[OFF_W-1:0] == '0);
        mar_next_o = take_o ? {dcr_i[PAGE_W-1:0], {OFF_W{1'b0}}} : inc;
        irq_o      = take_o && dcr_i[DCR_W-1];
    end
endmodule

// File: rtl/ilc_wc_step.sv
// Word-count decrement modulo 2^WCR_W and zero detection.
module ilc_wc_step #(
    parameter int WCR_W = 15
) (
    input  logic [WCR_W-1:0] wcr_i,
    output logic [WCR_W-1:0] wcr_dec_o,
    output logic             dec_zero_o,
    output logic             zero_o
);
    always_comb begin
        wcr_dec_o  = wcr_i - WCR_W'(1);
        dec_zero_o = (wcr_dec_o == '0);
        zero_o     = (wcr_i == '0);
    end
endmodule

// File: rtl/ilc_chain_unit.sv
module ilc_chain_unit
    import ilc_pkg::*;
#(
    parameter int MAR_W   = 16,
    parameter int OFF_W   = 11,
    parameter int WCR_W   = 15,
    parameter int WC_LO_W = 10,
    parameter int MA_LO_W = 14,
    localparam int PAGE_W  = MAR_W - OFF_W,
    localparam int DCR_W   = PAGE_W + 1,
    localparam int CTL_W   = WC_LO_W + MA_LO_W,
    localparam int HI_MA_W = MAR_W - MA_LO_W,
    localparam int HI_WC_W = WCR_W - WC_LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alert_i,
    input  logic             ilc_load_i,
    input  logic             mode_load_i,
    input  logic [CTL_W-1:0] ctl_word_i,
    input  logic             dcr_load_i,
    input  logic [DCR_W-1:0] dcr_i,
    input  logic             step_i,
    input  logic             rd_req_i,
    output logic [MAR_W-1:0] mar_o,
    output logic [WCR_W-1:0] wcr_o,
    output logic             wc_zero_o,
    output logic             ilce_o,
    output logic             chain_pend_o,
    output logic             chain_irq_o,
    output logic             rd_vld_o,
    output logic [MAR_W-1:0] rd_mar_o
);
    ilc_state_e       state_q, state_d;
    logic [MAR_W-1:0] mar_q;
    logic [WCR_W-1:0] wcr_q;
    logic [DCR_W-1:0] dcr_q;
    logic             pend_q;
    logic             irq_q;
    logic             rdv_q;
    logic [MAR_W-1:0] rdm_q;

    logic [MAR_W-1:0] step_mar;
    logic             step_take;
    logic             step_irq;
    logic [WCR_W-1:0] wc_dec;
    logic             wc_dec_zero;
    logic             wc_zero;

    logic do_alert, do_ilc, do_mode, do_step;

    // Command priority: alert > interlace load > mode load > step (R12)
    always_comb begin
        do_alert = alert_i;
        do_ilc   = ilc_load_i && !alert_i;
        do_mode  = mode_load_i && !alert_i && !ilc_load_i;
        do_step  = step_i && !alert_i && !ilc_load_i && !mode_load_i
                   && (state_q == ST_ACTIVE);
    end

    ilc_addr_step #(.MAR_W(MAR_W), .OFF_W(OFF_W)) u_addr (
        .mar_i      (mar_q),
        .pend_i     (pend_q),
        .dcr_i      (dcr_q),
        .mar_next_o (step_mar),
        .take_o     (step_take),
        .irq_o      (step_irq)
    );

    ilc_wc_step #(.WCR_W(WCR_W)) u_wc (
        .wcr_i      (wcr_q),
        .wcr_dec_o  (wc_dec),
        .dec_zero_o (wc_dec_zero),
        .zero_o     (wc_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ALERTED: begin
                if (do_alert)    state_d = ST_ALERTED;
                else if (do_ilc) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (do_alert)                        state_d = ST_ALERTED;
                else if (do_ilc)                     state_d = ST_ACTIVE;
                else if (do_step && wc_dec_zero)     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Address, count and chain registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q  <= '0;
            wcr_q  <= '0;
            dcr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (do_alert) begin
                mar_q <= '0;
                wcr_q <= '0;
            end else if (do_ilc) begin
                mar_q[MA_LO_W-1:0] <= ctl_word_i[MA_LO_W-1:0];
                wcr_q[WC_LO_W-1:0] <= ctl_word_i[CTL_W-1:MA_LO_W];
            end else if (do_mode) begin
                mar_q[MAR_W-1:MA_LO_W] <= ctl_word_i[HI_MA_W-1:0];
                wcr_q[WCR_W-1:WC_LO_W] <= ctl_word_i[HI_MA_W +: HI_WC_W];
            end else if (do_step) begin
                mar_q <= step_mar;
                wcr_q <= wc_dec;
            end
            if (dcr_load_i) begin
                dcr_q  <= dcr_i;
                pend_q <= 1'b1;
            end else if (do_step && step_take) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Registered outputs: interrupt pulse and readback
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            rdv_q <= 1'b0;
            rdm_q <= '0;
        end else begin
            irq_q <= do_step && step_irq;
            rdv_q <= rd_req_i;
            if (rd_req_i) rdm_q <= mar_q;
        end
    end

    assign mar_o        = mar_q;
    assign wcr_o        = wcr_q;
    assign wc_zero_o    = wc_zero;
    assign ilce_o       = (state_q == ST_ACTIVE);
    assign chain_pend_o = pend_q;
    assign chain_irq_o  = irq_q;
    assign rd_vld_o     = rdv_q;
    assign rd_mar_o     = rdm_q;
endmodule

// File: rtl/ilc_chain_unit_chk.sv
module ilc_chain_unit_chk #(
    parameter int MAR_W   = 16,
    parameter int OFF_W   = 11,
    parameter int WCR_W   = 15,
    parameter int WC_LO_W = 10,
    parameter int MA_LO_W = 14,
    localparam int DCR_W  = MAR_W - OFF_W + 1,
    localparam int CTL_W  = WC_LO_W + MA_LO_W
) (
    input logic             clk,
    input logic             rst,
    input logic             alert_i,
    input logic             ilc_load_i,
    input logic             mode_load_i,
    input logic [CTL_W-1:0] ctl_word_i,
    input logic             dcr_load_i,
    input logic [DCR_W-1:0] dcr_i,
    input logic             step_i,
    input logic             rd_req_i,
    input logic [MAR_W-1:0] mar_o,
    input logic [WCR_W-1:0] wcr_o,
    input logic             wc_zero_o,
    input logic             ilce_o,
    input logic             chain_pend_o,
    input logic             chain_irq_o,
    input logic             rd_vld_o,
    input logic [MAR_W-1:0] rd_mar_o
);
    logic only_step;
    assign only_step = step_i && !alert_i && !ilc_load_i && !mode_load_i;

    p_alert_clears_r11: assert property (@(posedge clk) disable iff (rst)
        alert_i |=> (mar_o == '0 && wcr_o == '0 && !ilce_o));

    p_load_enables_r2: assert property (@(posedge clk) disable iff (rst)
        (ilc_load_i && !alert_i) |=>
            (ilce_o && mar_o[MA_LO_W-1:0] == $past(ctl_word_i[MA_LO_W-1:0])));

    p_idle_step_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (only_step && !ilce_o) |=> ($stable(mar_o) && $stable(wcr_o)));

    p_count_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (only_step && ilce_o && wcr_o == '0) |=> (wcr_o == '1 && ilce_o));

    p_irq_needs_chain_r6: assert property (@(posedge clk) disable iff (rst)
        chain_irq_o |-> ($past(chain_pend_o) && mar_o[OFF_W-1:0] == '0));

    p_readback_r7: assert property (@(posedge clk) disable iff (rst)
        rd_vld_o |-> (rd_mar_o == $past(mar_o)));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (only_step && ilce_o && wcr_o == WCR_W'(1)) |=> (wc_zero_o && !ilce_o));
endmodule

bind ilc_chain_unit ilc_chain_unit_chk #(
    .MAR_W(MAR_W), .OFF_W(OFF_W), .WCR_W(WCR_W),
    .WC_LO_W(WC_LO_W), .MA_LO_W(MA_LO_W)
) u_chk (
    .clk(clk), .rst(rst), .alert_i(alert_i), .ilc_load_i(ilc_load_i),
    .mode_load_i(mode_load_i), .ctl_word_i(ctl_word_i),
    .dcr_load_i(dcr_load_i), .dcr_i(dcr_i), .step_i(step_i),
    .rd_req_i(rd_req_i), .mar_o(mar_o), .wcr_o(wcr_o),
    .wc_zero_o(wc_zero_o), .ilce_o(ilce_o), .chain_pend_o(chain_pend_o),
    .chain_irq_o(chain_irq_o), .rd_vld_o(rd_vld_o), .rd_mar_o(rd_mar_o)
);

// File: tb/ilc_chain_unit_bench.sv
module ilc_chain_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alert_i = 0, ilc_load_i = 0, mode_load_i = 0;
    logic [23:0] ctl_word_i = '0;
    logic        dcr_load_i = 0;
    logic [5:0]  dcr_i = '0;
    logic        step_i = 0, rd_req_i = 0;
    logic [15:0] mar_o, rd_mar_o;
    logic [14:0] wcr_o;
    logic        wc_zero_o, ilce_o, chain_pend_o, chain_irq_o, rd_vld_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    ilc_chain_unit u_ilc_chain_unit (
        .clk(clk), .rst(rst), .alert_i(alert_i), .ilc_load_i(ilc_load_i),
        .mode_load_i(mode_load_i), .ctl_word_i(ctl_word_i),
        .dcr_load_i(dcr_load_i), .dcr_i(dcr_i), .step_i(step_i),
        .rd_req_i(rd_req_i), .mar_o(mar_o), .wcr_o(wcr_o),
        .wc_zero_o(wc_zero_o), .ilce_o(ilce_o), .chain_pend_o(chain_pend_o),
        .chain_irq_o(chain_irq_o), .rd_vld_o(rd_vld_o), .rd_mar_o(rd_mar_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected readback values from the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_vld_o) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R7 unexpected readback actual=%0h expected=none", rd_mar_o);
            end else begin
                chk("R7 readback", {16'h0, rd_mar_o}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic do_alert;
        @(negedge clk); alert_i = 1; @(negedge clk); alert_i = 0;
    endtask
    task automatic do_ilc(input logic [23:0] w);
        @(negedge clk); ilc_load_i = 1; ctl_word_i = w; @(negedge clk); ilc_load_i = 0;
    endtask
    task automatic do_mode(input logic [23:0] w);
        @(negedge clk); mode_load_i = 1; ctl_word_i = w; @(negedge clk); mode_load_i = 0;
    endtask
    task automatic do_dcr(input logic [5:0] d);
        @(negedge clk); dcr_load_i = 1; dcr_i = d; @(negedge clk); dcr_load_i = 0;
    endtask
    task automatic do_step;
        @(negedge clk); step_i = 1; @(negedge clk); step_i = 0;
    endtask
    task automatic do_read(input logic [15:0] expect_mar);
        exp_q.push_back(expect_mar);
        @(negedge clk); rd_req_i = 1; @(negedge clk); rd_req_i = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mar", mar_o, 0);
        chk("R1 wcr", wcr_o, 0);
        chk("R1 flags", {wc_zero_o, ilce_o, chain_pend_o, chain_irq_o, rd_vld_o}, 5'b10000);

        // R2 interlace load after alert
        do_alert();
        do_ilc(24'h00C7FE);               // wc=3, addr=07FE
        chk("R2 mar", mar_o, 16'h07FE);
        chk("R2 wcr", wcr_o, 15'h0003);
        chk("R2 ilce", ilce_o, 1);

        // R3 mode word high fields
        do_mode(24'h000005);              // hi mar=01, hi wc=00001
        chk("R3 mar", mar_o, 16'h47FE);
        chk("R3 wcr", wcr_o, 15'h0403);

        // R4 chain write
        do_dcr(6'b1_00011);
        chk("R4 pend", chain_pend_o, 1);

        // R5 plain step, pending held
        do_step();
        chk("R5 mar", mar_o, 16'h47FF);
        chk("R5 wcr", wcr_o, 15'h0402);
        chk("R4 pend held", chain_pend_o, 1);
        chk("R6 no irq off boundary", chain_irq_o, 0);

        // R6 chain jump with interrupt
        do_step();
        chk("R6 mar jump", mar_o, 16'h1800);
        chk("R6 irq", chain_irq_o, 1);
        chk("R6 pend clr", chain_pend_o, 0);
        chk("R5 wcr", wcr_o, 15'h0401);
        do_step();
        chk("R6 one shot mar", mar_o, 16'h1801);
        chk("R6 irq drop", chain_irq_o, 0);

        // R7 readback
        do_read(16'h1801);

        // R11 alert clears
        do_alert();
        chk("R11 mar", mar_o, 0);
        chk("R11 wcr", wcr_o, 0);
        chk("R11 ilce", ilce_o, 0);

        // R6 chain jump without interrupt, R8 drain
        do_dcr(6'b0_00101);
        do_ilc(24'h0087FF);               // wc=2, addr=07FF
        do_step();
        chk("R6 mar jump noirq", mar_o, 16'h2800);
        chk("R6 no irq", chain_irq_o, 0);
        chk("R6 pend clr", chain_pend_o, 0);
        do_step();
        chk("R8 ilce off", ilce_o, 0);
        chk("R8 wc zero", wc_zero_o, 1);
        chk("R8 mar", mar_o, 16'h2801);

        // R9 step ignored while idle
        do_step();
        chk("R9 mar", mar_o, 16'h2801);
        chk("R9 wcr", wcr_o, 0);
        do_read(16'h2801);

        // R10 wrap from zero count
        do_alert();
        do_ilc(24'h000010);
        chk("R10 pre zero", {ilce_o, wc_zero_o}, 2'b11);
        do_step();
        chk("R10 wrap", wcr_o, 15'h7FFF);
        chk("R10 active", ilce_o, 1);
        chk("R10 mar", mar_o, 16'h0011);

        // R12 priority: load beats step
        @(negedge clk); ilc_load_i = 1; step_i = 1; ctl_word_i = 24'h000020;
        @(negedge clk); ilc_load_i = 0; step_i = 0;
        chk("R12 load over step mar", mar_o, 16'h0020);
        chk("R12 load over step wcr", wcr_o, 15'h7C00);
        // R12 priority: alert beats load
        @(negedge clk); alert_i = 1; ilc_load_i = 1; ctl_word_i = 24'h00C123;
        @(negedge clk); alert_i = 0; ilc_load_i = 0;
        chk("R12 alert over load mar", mar_o, 0);
        chk("R12 alert over load ilce", ilce_o, 0);

        repeat (3) @(negedge clk);
        chk("R7 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule